// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Level Flags

A 64-entry, 36-bit first-in first-out store that carries words from a producer running on one clock to a consumer running on another. The two clocks may be unrelated or the same clock. Each side has an active-low select and an active-high enable, and a word moves on a rising edge only when both are in their active state and the side's own flag allows it. Each side sees active-low flags in its own clock domain. The write side has a full flag and an almost-full flag. The read side has an empty flag and an almost-empty flag. Data leaves through a registered output.

One asynchronous reset input is synchronised separately into each domain. The release is synchronous and the assertion is asynchronous. A 6-bit threshold X is captured from `ofs_in` while each side is still starting up, or is set to 8 when `ofs_load` is low. Almost-empty compares the stored word count with X. Almost-full compares the number of free slots with X. The pointers cross between the domains in Gray code through two-flop synchronisers.

The write side runs a small start-up machine with three states: `WS_HOLD`, `WS_ARM` and `WS_RUN`. Its transitions are HOLD→ARM on the first edge after the local reset releases, ARM→RUN on the next edge, and RUN→RUN from then on. A local reset returns it to HOLD. The read side has two states: `RS_CAPTURE` moves to `RS_LIVE` on the first edge after its local reset releases, and a local reset returns it to `RS_CAPTURE`. Each side loads X on every edge while its machine is in the first state.

Top module: `cdc_flag_fifo`

## Requirements
- R1: A write happens only on a `wr_clk` rising edge where `wr_sel_n`=0, `wr_en`=1 and `wr_full_n`=1. A read happens only on a `rd_clk` rising edge where `rd_sel_n`=0, `rd_en`=1 and `rd_empty_n`=1. With either control inactive, nothing is stored or removed.
- R2: Words leave in the order they were written. `rd_data` takes the next word on the edge of an accepted read and holds its value between reads.
- R3: `rd_empty_n` is 0 whenever the read side sees no stored words. Read attempts while it is 0 leave `rd_data` and the contents unchanged.
- R4: After a word is written into an empty store, `rd_empty_n` becomes 1 after the second `rd_clk` rising edge that follows the write edge.
- R5: `wr_full_n` is 0 while the write side counts 64 stored words. Write attempts while it is 0 are discarded.
- R6: The local reset of each side releases on the second rising edge of that side's clock after `rst_n` rises. `wr_full_n` is 0 during reset and becomes 1 after the second `wr_clk` rising edge following the local release.
- R7: `rd_aempty_n` is 0 exactly when the word count seen by the read side is less than or equal to X.
- R8: `wr_afull_n` is 0 exactly when 64 minus the word count seen by the write side is less than or equal to X, or when the write side has not yet reached `WS_RUN`.
- R9: X equals `ofs_in` when `ofs_load`=1 during start-up, and equals 8 when `ofs_load`=0.
- R10: Reset empties the store, clears both pointers and sets `rd_data` to 0, with all four flags at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low, for both sides |
| ofs_load | input | 1 | 1: take X from ofs_in at start-up; 0: X = 8 |
| ofs_in | input | 6 | Threshold value X |
| wr_clk | input | 1 | Write-side clock |
| wr_sel_n | input | 1 | Write-side select, active low |
| wr_en | input | 1 | Write-side enable, active high |
| wr_data | input | 36 | Word to store |
| wr_full_n | output | 1 | Low when full or starting up |
| wr_afull_n | output | 1 | Low when free slots ≤ X |
| rd_clk | input | 1 | Read-side clock |
| rd_sel_n | input | 1 | Read-side select, active low |
| rd_en | input | 1 | Read-side enable, active high |
| rd_data | output | 36 | Registered output word |
| rd_empty_n | output | 1 | Low when no words are stored |
| rd_aempty_n | output | 1 | Low when stored words ≤ X |

## Verification
The properties assume that both clocks run while reset is held. They also assume that `ofs_load` and `ofs_in` stay constant from the assertion of reset until both start-up machines have left their first state, because both domains sample those inputs independently. The bench drives the two ports from one shared clock, which is the coincident case. It changes the threshold inputs only together with a new reset and then holds them for several cycles after the release. This lets a behavioural queue model predict every flag on every cycle, including the two-edge synchroniser latencies.

// File: rtl/cdc_flag_fifo_pkg.sv
package cdc_flag_fifo_pkg;

    typedef enum logic [1:0] {
        WS_HOLD = 2'd0,
        WS_ARM  = 2'd1,
        WS_RUN  = 2'd2
    } wr_phase_e;

    typedef enum logic {
        RS_CAPTURE = 1'b0,
        RS_LIVE    = 1'b1
    } rd_phase_e;

endpackage

// File: rtl/cdc_rst_sync.sv
module cdc_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_l_n
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end

    assign rst_l_n = chain_q[STAGES-1];
endmodule

// File: rtl/cdc_gray_sync.sv
module cdc_gray_sync #(
    parameter int W      = 7,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_l_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] gray_out
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_l_n) begin
                if (!rst_l_n) stage_q[s] <= '0;
                else          stage_q[s] <= gray_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_l_n) begin
                if (!rst_l_n) stage_q[s] <= '0;
                else          stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign gray_out = stage_q[STAGES-1];
endmodule

// File: rtl/cdc_fifo_wside.sv
module cdc_fifo_wside
    import cdc_flag_fifo_pkg::*;
#(
    parameter int AW    = 6,
    parameter int XW    = 6,
    parameter int SYNC  = 2,
    parameter int X_DEF = 8,
    localparam int PW    = AW + 1,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_l_n,
    input  logic          sel_n,
    input  logic          en,
    input  logic          ofs_load,
    input  logic [XW-1:0] ofs_in,
    input  logic [PW-1:0] r_gray_async,
    output logic [PW-1:0] w_gray,
    output logic [AW-1:0] waddr,
    output logic          we,
    output logic [PW-1:0] occ,
    output logic          full_n,
    output logic          afull_n
);
    wr_phase_e     state_q, state_d;
    logic [PW-1:0] wbin_q, wbin_nx, r_gray_s, r_bin_s, free_slots;
    logic [XW-1:0] x_q;
    logic          run;

    // state register
    always_ff @(posedge clk or negedge rst_l_n) begin
        if (!rst_l_n) state_q <= WS_HOLD;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_HOLD: state_d = WS_ARM;
            WS_ARM:  state_d = WS_RUN;
            WS_RUN:  state_d = WS_RUN;
            default: state_d = WS_HOLD;
        endcase
    end

    // outputs of the machine
    always_comb begin
        run     = (state_q == WS_RUN);
        full_n  = run && (occ != PW'(DEPTH));
        afull_n = run && (free_slots > PW'(x_q));
    end

    always_ff @(posedge clk) begin
        if (state_q == WS_HOLD) x_q <= ofs_load ? ofs_in : XW'(X_DEF);
    end

    assign we      = !sel_n && en && full_n;
    assign wbin_nx = wbin_q + PW'(1);

    always_ff @(posedge clk or negedge rst_l_n) begin
        if (!rst_l_n) begin
            wbin_q <= '0;
            w_gray <= '0;
        end else if (we) begin
            wbin_q <= wbin_nx;
            w_gray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    cdc_gray_sync #(.W(PW), .STAGES(SYNC)) u_rsync (
        .clk      (clk),
        .rst_l_n  (rst_l_n),
        .gray_in  (r_gray_async),
        .gray_out (r_gray_s)
    );

    for (genvar b = 0; b < PW; b++) begin : g_g2b
        assign r_bin_s[b] = ^r_gray_s[PW-1:b];
    end

    assign occ        = wbin_q - r_bin_s;
    assign free_slots = PW'(DEPTH) - occ;
    assign waddr      = wbin_q[AW-1:0];
endmodule

// File: rtl/cdc_fifo_rside.sv
module cdc_fifo_rside
    import cdc_flag_fifo_pkg::*;
#(
    parameter int AW    = 6,
    parameter int DW    = 36,
    parameter int XW    = 6,
    parameter int SYNC  = 2,
    parameter int X_DEF = 8,
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_l_n,
    input  logic          sel_n,
    input  logic          en,
    input  logic          ofs_load,
    input  logic [XW-1:0] ofs_in,
    input  logic [PW-1:0] w_gray_async,
    input  logic [DW-1:0] mem_word,
    output logic [PW-1:0] r_gray,
    output logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata,
    output logic          empty_n,
    output logic          aempty_n
);
    rd_phase_e     state_q, state_d;
    logic [PW-1:0] rbin_q, rbin_nx, w_gray_s, w_bin_s, fill;
    logic [XW-1:0] x_q;
    logic          re;

    // state register
    always_ff @(posedge clk or negedge rst_l_n) begin
        if (!rst_l_n) state_q <= RS_CAPTURE;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_CAPTURE: state_d = RS_LIVE;
            RS_LIVE:    state_d = RS_LIVE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (state_q == RS_CAPTURE) x_q <= ofs_load ? ofs_in : XW'(X_DEF);
    end

    cdc_gray_sync #(.W(PW), .STAGES(SYNC)) u_wsync (
        .clk      (clk),
        .rst_l_n  (rst_l_n),
        .gray_in  (w_gray_async),
        .gray_out (w_gray_s)
    );

    for (genvar b = 0; b < PW; b++) begin : g_g2b
        assign w_bin_s[b] = ^w_gray_s[PW-1:b];
    end

    // outputs
    always_comb begin
        fill     = w_bin_s - rbin_q;
        empty_n  = (w_gray_s != r_gray);
        aempty_n = (fill > PW'(x_q));
    end

    assign re      = !sel_n && en && empty_n;
    assign rbin_nx = rbin_q + PW'(1);
    assign raddr   = rbin_q[AW-1:0];

    always_ff @(posedge clk or negedge rst_l_n) begin
        if (!rst_l_n) begin
            rbin_q <= '0;
            r_gray <= '0;
            rdata  <= '0;
        end else if (re) begin
            rbin_q <= rbin_nx;
            r_gray <= rbin_nx ^ (rbin_nx >> 1);
            rdata  <= mem_word;
        end
    end
endmodule

// File: rtl/cdc_flag_fifo.sv
module cdc_flag_fifo #(
    parameter int AW    = 6,
    parameter int DW    = 36,
    parameter int XW    = 6,
    parameter int SYNC  = 2,
    parameter int X_DEF = 8
) (
    input  logic          rst_n,
    input  logic          ofs_load,
    input  logic [XW-1:0] ofs_in,
    input  logic          wr_clk,
    input  logic          wr_sel_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          wr_full_n,
    output logic          wr_afull_n,
    input  logic          rd_clk,
    input  logic          rd_sel_n,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_empty_n,
    output logic          rd_aempty_n
);
    localparam int PW    = AW + 1;
    localparam int DEPTH = 1 << AW;

    logic          wr_rl_n, rd_rl_n, w_we;
    logic [PW-1:0] w_gray, r_gray, w_occ;
    logic [AW-1:0] w_addr, r_addr;
    logic [DW-1:0] mem_rd;
    logic [DW-1:0] store_q [DEPTH];

    cdc_rst_sync #(.STAGES(SYNC)) u_wrst (
        .clk (wr_clk), .arst_n (rst_n), .rst_l_n (wr_rl_n)
    );

    cdc_rst_sync #(.STAGES(SYNC)) u_rrst (
        .clk (rd_clk), .arst_n (rst_n), .rst_l_n (rd_rl_n)
    );

    cdc_fifo_wside #(.AW(AW), .XW(XW), .SYNC(SYNC), .X_DEF(X_DEF)) u_wside (
        .clk          (wr_clk),
        .rst_l_n      (wr_rl_n),
        .sel_n        (wr_sel_n),
        .en           (wr_en),
        .ofs_load     (ofs_load),
        .ofs_in       (ofs_in),
        .r_gray_async (r_gray),
        .w_gray       (w_gray),
        .waddr        (w_addr),
        .we           (w_we),
        .occ          (w_occ),
        .full_n       (wr_full_n),
        .afull_n      (wr_afull_n)
    );

    always_ff @(posedge wr_clk) begin
        if (w_we) store_q[w_addr] <= wr_data;
    end

    assign mem_rd = store_q[r_addr];

    cdc_fifo_rside #(.AW(AW), .DW(DW), .XW(XW), .SYNC(SYNC), .X_DEF(X_DEF)) u_rside (
        .clk          (rd_clk),
        .rst_l_n      (rd_rl_n),
        .sel_n        (rd_sel_n),
        .en           (rd_en),
        .ofs_load     (ofs_load),
        .ofs_in       (ofs_in),
        .w_gray_async (w_gray),
        .mem_word     (mem_rd),
        .r_gray       (r_gray),
        .raddr        (r_addr),
        .rdata        (rd_data),
        .empty_n      (rd_empty_n),
        .aempty_n     (rd_aempty_n)
    );
endmodule

// File: rtl/cdc_flag_fifo_chk.sv
module cdc_flag_fifo_chk #(
    parameter int PW = 7,
    parameter int DW = 36
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          wr_rl_n,
    input logic          rd_rl_n,
    input logic          wr_full_n,
    input logic          wr_afull_n,
    input logic          rd_empty_n,
    input logic          rd_aempty_n,
    input logic [DW-1:0] rd_data,
    input logic [PW-1:0] w_gray,
    input logic [PW-1:0] r_gray,
    input logic [PW-1:0] w_occ
);
    localparam int DEPTH = 1 << (PW - 1);

    // R5
    no_write_when_full_chk: assert property (@(posedge wr_clk) disable iff (!wr_rl_n)
        !wr_full_n |=> $stable(w_gray));

    // R3
    no_read_when_empty_chk: assert property (@(posedge rd_clk) disable iff (!rd_rl_n)
        !rd_empty_n |=> $stable(rd_data) && $stable(r_gray));

    // R6
    full_held_after_reset_chk: assert property (@(posedge wr_clk) disable iff (!wr_rl_n)
        !$past(wr_rl_n) |-> !wr_full_n);

    // R7
    aempty_above_empty_chk: assert property (@(posedge rd_clk) disable iff (!rd_rl_n)
        rd_aempty_n |-> rd_empty_n);

    // R8
    afull_above_full_chk: assert property (@(posedge wr_clk) disable iff (!wr_rl_n)
        wr_afull_n |-> wr_full_n);

    // R5
    occupancy_bound_chk: assert property (@(posedge wr_clk) disable iff (!wr_rl_n)
        w_occ <= PW'(DEPTH));

    // R4
    wgray_single_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rl_n)
        $onehot0(w_gray ^ $past(w_gray)));

    // R4
    rgray_single_step_chk: assert property (@(posedge rd_clk) disable iff (!rd_rl_n)
        $onehot0(r_gray ^ $past(r_gray)));
endmodule

bind cdc_flag_fifo cdc_flag_fifo_chk #(.PW(AW + 1), .DW(DW)) u_chk (
    .wr_clk      (wr_clk),
    .rd_clk      (rd_clk),
    .wr_rl_n     (wr_rl_n),
    .rd_rl_n     (rd_rl_n),
    .wr_full_n   (wr_full_n),
    .wr_afull_n  (wr_afull_n),
    .rd_empty_n  (rd_empty_n),
    .rd_aempty_n (rd_aempty_n),
    .rd_data     (rd_data),
    .w_gray      (w_gray),
    .r_gray      (r_gray),
    .w_occ       (w_occ)
);

// File: tb/cdc_flag_fifo_tb.sv
module cdc_flag_fifo_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0, ofs_load = 1'b1;
    logic [5:0]  ofs_in = 6'd5;
    logic        wr_sel_n = 1'b1, wr_en = 1'b0, rd_sel_n = 1'b1, rd_en = 1'b0;
    logic [35:0] wr_data = '0;
    logic [35:0] rd_data;
    logic        wr_full_n, wr_afull_n, rd_empty_n, rd_aempty_n;

    cdc_flag_fifo u_dut (
        .rst_n (rst_n), .ofs_load (ofs_load), .ofs_in (ofs_in),
        .wr_clk (clk), .wr_sel_n (wr_sel_n), .wr_en (wr_en), .wr_data (wr_data),
        .wr_full_n (wr_full_n), .wr_afull_n (wr_afull_n),
        .rd_clk (clk), .rd_sel_n (rd_sel_n), .rd_en (rd_en), .rd_data (rd_data),
        .rd_empty_n (rd_empty_n), .rd_aempty_n (rd_aempty_n)
    );

    int    n_cmp = 0, n_bad = 0;
    string phase = "R10 reset";
    bit    chk_on = 1'b0, finished = 1'b0;

    // behavioural model
    int          wtot = 0, rtot = 0, ws1 = 0, ws2 = 0, rs1 = 0, rs2 = 0;
    int          l1 = 0, l2 = 0, wrun = 0, mx = 5;
    logic [35:0] mdata = '0;
    logic [35:0] q [$];
    bit          fn, en_, wacc, racc;

    always @(posedge clk or negedge rst_n) begin
        if (wrun == 0) mx = ofs_load ? int'(ofs_in) : 8;
        if (!rst_n) begin
            l1 = 0; l2 = 0; wrun = 0; wtot = 0; rtot = 0;
            ws1 = 0; ws2 = 0; rs1 = 0; rs2 = 0; mdata = '0; q.delete();
        end else begin
            fn   = (wrun == 2) && ((wtot - rs2) != 64);
            en_  = (ws2 != rtot);
            wacc = !wr_sel_n && wr_en && fn;
            racc = !rd_sel_n && rd_en && en_;
            if (l2 != 0 && wrun < 2) wrun++;
            ws2 = ws1; ws1 = wtot; rs2 = rs1; rs1 = rtot;
            if (wacc) begin q.push_back(wr_data); wtot++; end
            if (racc) begin mdata = q.pop_front(); rtot++; end
            l2 = l1; l1 = 1;
        end
    end

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s during %s: actual %h expected %h", req, phase, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on && !finished) begin
            chk("R2 rd_data", rd_data, mdata);
            chk("R3 rd_empty_n", 36'(rd_empty_n), 36'(ws2 != rtot));
            chk("R5 wr_full_n", 36'(wr_full_n), 36'((wrun == 2) && ((wtot - rs2) != 64)));
            chk("R7 rd_aempty_n", 36'(rd_aempty_n), 36'((ws2 - rtot) > mx));
            chk("R8 wr_afull_n", 36'(wr_afull_n), 36'((wrun == 2) && ((64 - (wtot - rs2)) > mx)));
        end
    end

    int seq = 1;

    task automatic cyc(input logic ws, input logic we_, input logic rs, input logic re_);
        @(negedge clk); #1;
        wr_sel_n = ws; wr_en = we_; rd_sel_n = rs; rd_en = re_;
        wr_data  = {4'hA, 32'(seq * 32'h9E37)};
        seq++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic do_reset(input logic ld, input logic [5:0] v);
        @(negedge clk); #1;
        rst_n = 1'b0; ofs_load = ld; ofs_in = v;
        wr_sel_n = 1'b1; wr_en = 1'b0; rd_sel_n = 1'b1; rd_en = 1'b0;
        idle(4);
        @(negedge clk); #1;
        rst_n = 1'b1;
        idle(6);
    endtask

    task automatic fill_drain(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0);
        idle(4);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1);
        idle(4);
    endtask

    initial begin
        #((200000 * 10));
        if (!finished) begin
            finished = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] lfsr;
        lfsr = 32'hC0DE_1234;
        // R10: reset state, X loaded from ofs_in = 5
        idle(2);
        chk_on = 1'b1;
        idle(5);
        // R6: write attempts while the write side is starting up
        phase = "R6 startup";
        @(negedge clk); #1; rst_n = 1'b1;
        for (int i = 0; i < 6; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0);
        idle(2);
        for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1);
        idle(3);
        // R1: inactive select or enable moves nothing
        phase = "R1 qualify";
        for (int i = 0; i < 4; i++) cyc(1'b1, 1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0);
        idle(4);
        // R4: single word into empty store
        phase = "R4 first word";
        cyc(1'b0, 1'b1, 1'b1, 1'b0);
        idle(5);
        cyc(1'b1, 1'b0, 1'b0, 1'b1);
        idle(3);
        // R5: overfill, R3: overdrain
        phase = "R5 fill";
        for (int i = 0; i < 70; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0);
        idle(4);
        phase = "R3 drain";
        for (int i = 0; i < 70; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1);
        idle(4);
        // R9: default threshold and both extremes
        phase = "R9 default X";
        do_reset(1'b0, 6'd33);
        fill_drain(20);
        phase = "R9 X=0";
        do_reset(1'b1, 6'd0);
        fill_drain(66);
        phase = "R9 X=63";
        do_reset(1'b1, 6'd63);
        fill_drain(66);
        // R2: concurrent traffic, order preserved
        phase = "R2 mixed";
        do_reset(1'b1, 6'd4);
        for (int i = 0; i < 800; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cyc(lfsr[3], lfsr[7] | (i > 400 && i < 470), lfsr[11] & (i > 300), lfsr[13]);
        end
        idle(4);
        for (int i = 0; i < 70; i++) cyc(1'b1, 1'b0, 1'b0, 1'b1);
        idle(4);
        // R10: reset with data stored
        phase = "R10 reset";
        for (int i = 0; i < 10; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0);
        do_reset(1'b1, 6'd5);
        idle(2);
        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule